// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-bit Timer Registers

This block sits between an 8-bit processor data bus and the five 16-bit registers of a timer: the running count, three compare values and a captured value. The bus sees every 16-bit register as two byte addresses. A single 8-bit holding register is shared by all five words. It carries the upper byte between the two halves of an access, so the whole word always moves in one clock edge.

To write a word, software first writes the upper byte, which only loads the holding register. It then writes the lower byte. That second write presents the full word, holding byte on top and new byte below, to the target register with a one-cycle write enable. To read the count or the captured value, software reads the lower byte first. That read returns the live lower byte and, at the same edge, copies the live upper byte into the holding register. The following upper-byte read returns the holding register, so the two halves belong to the same instant. The compare registers are read directly, byte by byte, and never disturb the holding register. Read data is combinational in the strobe cycle.

Top module: `wide16_byte_bridge`

## Requirements
- R1: Byte address bits [3:1] pick the word: 0 count, 1 compare A, 2 compare B, 3 compare C, 4 capture. Bit 0 set means the upper byte. Word indices 5 to 7 are unmapped: a read there returns 0x00, and a write there changes neither the holding register nor any write enable.
- R2: A write to a mapped upper-byte address loads the holding register with the bus byte at that clock edge and raises no write enable.
- R3: A write to a mapped lower-byte address raises exactly one write enable, bit = word index, in that same cycle. The 16-bit write data is {holding register, bus byte}.
- R4: A read of the lower byte of the count or the capture word returns that word's live lower byte in the strobe cycle and loads the holding register with its live upper byte at that edge.
- R5: A read of the upper byte of the count or the capture word returns the holding register contents.
- R6: Reads of the compare words return the live lower or upper byte directly and leave the holding register unchanged.
- R7: The holding register is shared. An upper byte written at any word's address is committed by a lower-byte write to any word. A lower-byte snapshot read replaces a pending upper byte.
- R8: After reset the holding register is 0x00 and no write enable is raised.
- R9: In a cycle with no read strobe the read data is 0x00. In a cycle with no write strobe every write enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address: word index in [3:1], upper-byte select in [0] |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| reg_live | input | 80 | Live word values, word i at bits [16*i+15:16*i] |
| bus_rdata | output | 8 | Read byte, valid in the strobe cycle |
| reg_we | output | 5 | One-hot write enable per word |
| reg_wdata | output | 16 | Full word presented with a write enable |

## Verification
The embedded properties assume that the read and write strobes are never high in the same cycle and that both stay low while reset is asserted. They also assume that the live word inputs do not change between a strobe and the edge that ends it. The bench drives at most one strobe per cycle, keeps both strobes low during reset, and changes live values only just after a rising edge. Its pseudo-random phase mixes reads, writes and idle cycles over all sixteen addresses, including the unmapped ones, while the count word keeps advancing.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    // Where the read byte comes from in the strobe cycle
    typedef enum logic [1:0] {
        SRC_ZERO    = 2'd0,
        SRC_LIVE_LO = 2'd1,
        SRC_LIVE_HI = 2'd2,
        SRC_TEMP    = 2'd3
    } rd_src_e;

    // What the holding register does at the next edge
    typedef enum logic [1:0] {
        LD_HOLD  = 2'd0,
        LD_WRITE = 2'd1,
        LD_SNAP  = 2'd2
    } tmp_ld_e;

endpackage

// File: rtl/wbb_decode.sv
module wbb_decode #(
    parameter int ADDR_W = 4,
    parameter int NUM_REGS = 5,
    parameter logic [NUM_REGS-1:0] DIRECT_MASK = 5'b01110
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              valid,
    output logic              hi,
    output logic              direct,
    output logic [ADDR_W-2:0] idx
);
    localparam int IDX_W = ADDR_W - 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    always_comb begin
        idx    = addr[ADDR_W-1:1];
        hi     = addr[0];
        valid  = (idx <= LAST_IDX);
        direct = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) direct = DIRECT_MASK[i];
        end
    end
endmodule

// File: rtl/wbb_temp_reg.sv
module wbb_temp_reg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic              valid,
    input  logic              hi,
    input  logic              direct,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [BYTE_W-1:0] live_hi,
    output logic [BYTE_W-1:0] tmp_q
);
    import wbb_pkg::*;

    tmp_ld_e ld;

    always_comb begin
        if (wr && valid && hi)                 ld = LD_WRITE;
        else if (rd && valid && !hi && !direct) ld = LD_SNAP;
        else                                    ld = LD_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_q <= '0;
        end else begin
            unique case (ld)
                LD_WRITE: tmp_q <= wbyte;
                LD_SNAP:  tmp_q <= live_hi;
                default:  tmp_q <= tmp_q;
            endcase
        end
    end
endmodule

// File: rtl/wbb_read_mux.sv
module wbb_read_mux #(
    parameter int BYTE_W = 8
) (
    input  logic                rd,
    input  logic                valid,
    input  logic                hi,
    input  logic                direct,
    input  logic [2*BYTE_W-1:0] live_word,
    input  logic [BYTE_W-1:0]   tmp_q,
    output logic [BYTE_W-1:0]   rdata
);
    import wbb_pkg::*;

    rd_src_e src;

    always_comb begin
        if (!rd || !valid) src = SRC_ZERO;
        else if (!hi)      src = SRC_LIVE_LO;
        else if (direct)   src = SRC_LIVE_HI;
        else               src = SRC_TEMP;
    end

    always_comb begin
        unique case (src)
            SRC_LIVE_LO: rdata = live_word[BYTE_W-1:0];
            SRC_LIVE_HI: rdata = live_word[2*BYTE_W-1:BYTE_W];
            SRC_TEMP:    rdata = tmp_q;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/wide16_byte_bridge.sv
module wide16_byte_bridge #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4,
    parameter int NUM_REGS = 5,
    parameter logic [NUM_REGS-1:0] DIRECT_MASK = 5'b01110
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [BYTE_W-1:0]            bus_wdata,
    input  logic [NUM_REGS*2*BYTE_W-1:0] reg_live,
    output logic [BYTE_W-1:0]            bus_rdata,
    output logic [NUM_REGS-1:0]          reg_we,
    output logic [2*BYTE_W-1:0]          reg_wdata
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int IDX_W = ADDR_W - 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0] CNT_IDX = '0;

    logic              dec_valid, dec_hi, dec_direct;
    logic [IDX_W-1:0]  dec_idx;
    logic [WORD_W-1:0] live_word;
    logic [BYTE_W-1:0] tmp_q;

    wbb_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .DIRECT_MASK(DIRECT_MASK)
    ) u_decode (
        .addr(bus_addr), .valid(dec_valid), .hi(dec_hi),
        .direct(dec_direct), .idx(dec_idx)
    );

    always_comb begin
        live_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (dec_idx == IDX_W'(i)) live_word = reg_live[i*WORD_W +: WORD_W];
        end
    end

    wbb_temp_reg #(.BYTE_W(BYTE_W)) u_temp (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
        .valid(dec_valid), .hi(dec_hi), .direct(dec_direct),
        .wbyte(bus_wdata), .live_hi(live_word[WORD_W-1:BYTE_W]), .tmp_q(tmp_q)
    );

    wbb_read_mux #(.BYTE_W(BYTE_W)) u_rmux (
        .rd(bus_rd), .valid(dec_valid), .hi(dec_hi), .direct(dec_direct),
        .live_word(live_word), .tmp_q(tmp_q), .rdata(bus_rdata)
    );

    assign reg_wdata = {tmp_q, bus_wdata};

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
        assign reg_we[g] = bus_wr && dec_valid && !dec_hi && (dec_idx == IDX_W'(g));
    end

    // ---------------- embedded checks ----------------
    logic past_ok;
    logic addr_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end
    assign addr_ok = (bus_addr[ADDR_W-1:1] <= LAST_IDX);

    assert_hi_write_no_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0]) |-> (reg_we == '0));

    assert_we_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we));

    assert_pair_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_wr && bus_addr[0] && addr_ok) && bus_wr && !bus_addr[0] && addr_ok)
        |-> (reg_wdata[WORD_W-1:BYTE_W] == $past(bus_wdata)));

    assert_count_snapshot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_rd && !bus_addr[0] && bus_addr[ADDR_W-1:1] == CNT_IDX)
         && bus_rd && bus_addr == {CNT_IDX, 1'b1})
        |-> (bus_rdata == $past(reg_live[WORD_W-1:BYTE_W])));

    assert_cmp_read_keeps_temp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr_ok && DIRECT_MASK[bus_addr[ADDR_W-1:1]]) |=> $stable(tmp_q));

    assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    assert_idle_no_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> (reg_we == '0));

endmodule

// File: tb/wide16_byte_bridge_bench.sv
module wide16_byte_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata;
    logic [79:0] reg_live;
    logic [7:0]  bus_rdata;
    logic [4:0]  reg_we;
    logic [15:0] reg_wdata;

    logic [15:0] live_w [5];
    int          tmp_m;
    bit          cnt_run;
    int          vectors = 0;
    int          miscompares = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 5; i++) reg_live[i*16 +: 16] = live_w[i];
    end

    wide16_byte_bridge u_wide16_byte_bridge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .reg_live(reg_live),
        .bus_rdata(bus_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata)
    );

    // One bus cycle: drive, compare against the reference model, advance the model
    task automatic apply(input bit w, input bit r, input int a, input int d, input string req);
        int idx, hi, valid;
        logic [7:0]  exp_rd;
        logic [4:0]  exp_we;
        logic [15:0] exp_wd;
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a[3:0]; bus_wdata = d[7:0];
        #2;
        idx = a / 2; hi = a % 2; valid = (idx < 5);
        exp_rd = 8'h00;
        if (r && valid) begin
            if (hi == 0)                  exp_rd = live_w[idx][7:0];
            else if (idx >= 1 && idx <= 3) exp_rd = live_w[idx][15:8];
            else                          exp_rd = tmp_m[7:0];
        end
        exp_we = '0;
        exp_wd = {tmp_m[7:0], d[7:0]};
        if (w && valid && hi == 0) exp_we[idx] = 1'b1;
        vectors++;
        if (bus_rdata !== exp_rd || reg_we !== exp_we ||
            (exp_we != 0 && reg_wdata !== exp_wd)) begin
            miscompares++;
            $display("FAIL %s addr=%0d rdata=%h/%h we=%b/%b wdata=%h/%h (actual/expected)",
                     req, a, bus_rdata, exp_rd, reg_we, exp_we, reg_wdata, exp_wd);
        end
        if (w && valid && hi == 1) tmp_m = d & 8'hFF;
        if (r && valid && hi == 0 && (idx == 0 || idx == 4)) tmp_m = live_w[idx][15:8];
        @(posedge clk);
        #1;
        if (exp_we != 0) live_w[idx] = exp_wd;
        else if (cnt_run) live_w[0] = live_w[0] + 16'd1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        #100000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int unsigned seed;
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        tmp_m = 0; cnt_run = 0;
        live_w[0] = 16'h12FF; live_w[1] = 16'h1111; live_w[2] = 16'h2222;
        live_w[3] = 16'h3333; live_w[4] = 16'hC0DE;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        apply(0, 0, 0, 0, "R8 idle after reset");
        apply(0, 1, 1, 0, "R8 holding reg reset to zero");
        apply(0, 0, 5, 0, "R9 no strobe quiet");
        apply(1, 0, 3, 'hAB, "R2 upper write no enable");
        apply(0, 1, 1, 0, "R7 shared holding seen at count high");
        apply(1, 0, 2, 'hCD, "R3 lower write commits compare A");
        apply(0, 1, 2, 0, "R6 compare A low direct");
        apply(0, 1, 3, 0, "R6 compare A high direct");
        cnt_run = 1;
        live_w[0] = 16'h12FE;
        apply(0, 0, 0, 0, "R9 idle with counting");
        apply(0, 1, 0, 0, "R4 count low snapshot");
        apply(0, 1, 1, 0, "R5 count high from holding");
        apply(1, 0, 1, 'h55, "R2 upper write at count");
        apply(0, 1, 4, 0, "R6 compare B low read");
        apply(0, 1, 5, 0, "R6 compare B high read");
        apply(0, 1, 1, 0, "R6 holding untouched by compare reads");
        apply(1, 0, 9, 'h77, "R7 upper at capture address");
        apply(1, 0, 6, 'h11, "R7 commit to compare C");
        apply(1, 0, 7, 'h99, "R2 pending upper byte");
        apply(0, 1, 8, 0, "R4 capture low snapshot");
        apply(0, 1, 9, 0, "R5 capture high from holding");
        apply(1, 0, 0, 'h42, "R7 snapshot replaced pending byte");
        apply(1, 0, 11, 'hEE, "R1 unmapped upper write ignored");
        apply(0, 1, 9, 0, "R1 holding unchanged after unmapped write");
        apply(1, 0, 12, 'h01, "R1 unmapped lower write no enable");
        for (int a = 10; a < 16; a++) apply(0, 1, a, 0, "R1 unmapped read zero");

        seed = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            int op, a, d;
            seed = seed * 32'd1664525 + 32'd1013904223;
            op = int'(seed[31:30]);
            a  = int'(seed[19:16]);
            d  = int'(seed[11:4]);
            if (op == 0)      apply(1, 0, a, d, "R3 mixed write");
            else if (op == 3) apply(0, 0, a, d, "R9 mixed idle");
            else              apply(0, 1, a, d, "R4 mixed read");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule